// File: doc/BRIEF.md
# Buffered Period/Compare Timer

This block is a 16-bit up-counting timer. Each cycle it decides whether to count. The deciding signal comes from one of seven taps of a shared free-running prescaler or from one of four single-cycle event strobes. A 4-bit clock-select field in the control register picks the source, and the value zero stops the counter. The counter runs from zero up to a working period value and then wraps to zero. The cycle on which it wraps is the update condition, and it is reported on `update_o`.

The period register and each compare channel have two halves: a working register that the counter uses and a shadow buffer that software writes. Writing a buffer sets its valid flag. On the next update, every buffer whose flag is set copies into its working register and its flag clears. Software can therefore queue a new period or compare value at any time, and the counter picks it up only at a period boundary. The working registers can also be written directly. Each compare channel pulses its match output on any counting cycle where the counter equals that channel's working compare value.

An event-action mode lets a second event channel restart the counter. In that mode the count source must be an event channel. If the clock select names a prescaler tap instead, the counter does not run.

Top module: `buf_timer`

## Requirements
- R1: After reset the count is 0, the working period and every working compare are 16'hFFFF, all valid flags are clear and the clock select is 0. While the clock select (control bits [3:0]) is 0, the count does not change.
- R2: Clock select values 1 to 7 count on prescaler taps that divide the clock by 1, 2, 4, 8, 64, 256 and 1024. Over any 2048 consecutive cycles, tap k advances the count by exactly 2048 divided by its ratio.
- R3: Clock select values 8 to 11 count once for each cycle on which event channel 0 to 3 (event_i bit sel-8) is high. The count ignores strobes on every other channel.
- R4: The update condition is a counting cycle on which the count equals the working period. On that cycle `update_o` is high, and after that edge the count is 0.
- R5: Register addresses: 0 is control, 1 is the working period, 2 is the period buffer, 3+2i is the working compare of channel i and 4+2i is the buffer of channel i. A buffer write sets its valid flag (buf_valid_o bit 0 for the period, bit 1+i for compare i). The working value stays unchanged until the next update. At that update it takes the buffer value and the flag clears.
- R6: Suppose a buffer is written on the same cycle as an update. The working register then takes the buffer's previous value, the buffer keeps the new data, and the valid flag stays set for the following update.
- R7: `match_o[i]` is high exactly on the counting cycles where the count equals compare i's working value. On a cycle that does not count, it is low.
- R8: A write to a working register (address 1 or 3+2i) takes effect on the next cycle.
- R9: Control bit 4 enables the event action, and bits [6:5] name its channel. While the event action is enabled and the count source is an event channel, a strobe on the action channel sets the count to 0. That strobe raises no update and no match, and it takes priority over counting.
- R10: While the event action is enabled and the clock select is not an event channel, the count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W (4) | Register address |
| wr_data_i | input | CNT_W (16) | Write data |
| event_i | input | N_EV (4) | Single-cycle event strobes |
| count_o | output | CNT_W (16) | Current count |
| period_o | output | CNT_W (16) | Working period |
| buf_valid_o | output | N_CH+1 (5) | Valid flags: bit 0 for the period, bit 1+i for compare i |
| match_o | output | N_CH (4) | Compare match pulse per channel |
| update_o | output | 1 | Wrap / update pulse |

## Verification
The bench sweeps every prescaler tap over a 2048-cycle window. A tap decoded on the wrong bit would give a count delta that is off by a power of two. It drives all sixteen event masks against each event select, which catches a counter that responds to a neighbouring channel or to any strobe. The compare channels are swept against every count value of a short period, and a match that is late by one cycle or an off-by-one compare would fail those checks. The most delicate case is a buffer write that lands on the update cycle. A design that cleared the flag, or that loaded the new data straight into the working register, would show the wrong period immediately or would lose the queued value at the next wrap.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   localparam int unsigned SEL_W    = 4;
   localparam int unsigned N_TAPS   = 7;
   localparam int unsigned SEL_EV0  = 8;

   typedef struct packed {
      logic [1:0]       act_ch;
      logic             act_en;
      logic [SEL_W-1:0] sel;
   } tmr_ctrl_t;

   localparam int unsigned CTRL_W = $bits(tmr_ctrl_t);

   // log2 of the divide ratio for prescaler tap k
   function automatic int unsigned tap_shift(input int unsigned k);
      case (k)
         0: tap_shift = 0;
         1: tap_shift = 1;
         2: tap_shift = 2;
         3: tap_shift = 3;
         4: tap_shift = 6;
         5: tap_shift = 8;
         default: tap_shift = 10;
      endcase
   endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int unsigned PRE_W  = 10,
   parameter int unsigned N_TAPS = tmr_pkg::N_TAPS
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   output logic [N_TAPS-1:0] tap_o
);
   logic [PRE_W-1:0] pcnt_q;

   if (PRE_W < tmr_pkg::tap_shift(N_TAPS-1)) begin : g_bad_width
      $error("tmr_prescaler: PRE_W too small for the largest tap");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pcnt_q <= '0;
      else         pcnt_q <= pcnt_q + 1'b1;
   end

   for (genvar k = 0; k < N_TAPS; k++) begin : g_tap
      localparam int unsigned SH = tmr_pkg::tap_shift(k);
      if (SH == 0) begin : g_full
         assign tap_o[k] = 1'b1;
      end else begin : g_div
         assign tap_o[k] = &pcnt_q[SH-1:0];
      end
   end
endmodule

// File: rtl/tmr_shadow.sv
module tmr_shadow #(
   parameter int unsigned W        = 16,
   parameter logic [W-1:0] WORK_RST = '1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         wr_work_i,
   input  logic         wr_buf_i,
   input  logic [W-1:0] wdata_i,
   input  logic         update_i,
   output logic [W-1:0] work_o,
   output logic         valid_o
);
   logic [W-1:0] buf_q;
   logic [W-1:0] work_q;
   logic         valid_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         buf_q   <= '0;
         work_q  <= WORK_RST;
         valid_q <= 1'b0;
      end else begin
         if (wr_buf_i) buf_q <= wdata_i;
         if (wr_buf_i)      valid_q <= 1'b1;
         else if (update_i) valid_q <= 1'b0;
         if (update_i && valid_q) work_q <= buf_q;
         else if (wr_work_i)      work_q <= wdata_i;
      end
   end

   assign work_o  = work_q;
   assign valid_o = valid_q;
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
   parameter int unsigned W = 16
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         tick_i,
   input  logic         restart_i,
   input  logic [W-1:0] period_i,
   output logic [W-1:0] count_o,
   output logic         wrap_o
);
   logic [W-1:0] cnt_q;

   assign wrap_o = tick_i && !restart_i && (cnt_q == period_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      cnt_q <= '0;
      else if (restart_i) cnt_q <= '0;
      else if (wrap_o)  cnt_q <= '0;
      else if (tick_i)  cnt_q <= cnt_q + 1'b1;
   end

   assign count_o = cnt_q;
endmodule

// File: rtl/buf_timer.sv
module buf_timer #(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned N_CH   = 4,
   parameter int unsigned N_EV   = 4,
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned PRE_W  = 10
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [CNT_W-1:0]  wr_data_i,
   input  logic [N_EV-1:0]   event_i,
   output logic [CNT_W-1:0]  count_o,
   output logic [CNT_W-1:0]  period_o,
   output logic [N_CH:0]     buf_valid_o,
   output logic [N_CH-1:0]   match_o,
   output logic              update_o
);
   import tmr_pkg::*;

   localparam int unsigned A_CTRL  = 0;
   localparam int unsigned A_PER   = 1;
   localparam int unsigned A_PBUF  = 2;
   localparam int unsigned A_CMP0  = 3;
   localparam int unsigned N_ADDR  = A_CMP0 + 2 * N_CH;

   if (N_EV < 1 || N_EV > 4) begin : g_bad_ev
      $error("buf_timer: N_EV must be 1 to 4");
   end
   if (N_CH < 1) begin : g_bad_ch
      $error("buf_timer: N_CH must be at least 1");
   end
   if ((1 << ADDR_W) < N_ADDR) begin : g_bad_addr
      $error("buf_timer: ADDR_W too small for the register map");
   end
   if (CNT_W < CTRL_W) begin : g_bad_cnt
      $error("buf_timer: CNT_W narrower than the control word");
   end

   // control register
   tmr_ctrl_t ctrl_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ctrl_q <= '0;
      else if (wr_en_i && wr_addr_i == ADDR_W'(A_CTRL))
         ctrl_q <= tmr_ctrl_t'(wr_data_i[CTRL_W-1:0]);
   end

   // count source selection
   logic [N_TAPS-1:0] taps;
   tmr_prescaler #(.PRE_W(PRE_W), .N_TAPS(N_TAPS)) u_pre (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .tap_o (taps)
   );

   logic sel_is_ev;
   logic src_tick;
   logic tick;
   logic restart;
   logic act_hit;

   always_comb begin
      sel_is_ev = 1'b0;
      src_tick  = 1'b0;
      for (int unsigned k = 0; k < N_TAPS; k++)
         if (ctrl_q.sel == SEL_W'(k + 1)) src_tick = taps[k];
      for (int unsigned e = 0; e < N_EV; e++)
         if (ctrl_q.sel == SEL_W'(SEL_EV0 + e)) begin
            sel_is_ev = 1'b1;
            src_tick  = event_i[e];
         end
   end

   always_comb begin
      act_hit = 1'b0;
      for (int unsigned e = 0; e < N_EV; e++)
         if (ctrl_q.act_ch == 2'(e)) act_hit = event_i[e];
   end

   assign tick    = src_tick && (!ctrl_q.act_en || sel_is_ev);
   assign restart = ctrl_q.act_en && sel_is_ev && act_hit;

   // period register with shadow buffer
   logic [CNT_W-1:0] period_w;
   logic             upd;

   tmr_shadow #(.W(CNT_W), .WORK_RST('1)) u_per (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_work_i(wr_en_i && wr_addr_i == ADDR_W'(A_PER)),
      .wr_buf_i (wr_en_i && wr_addr_i == ADDR_W'(A_PBUF)),
      .wdata_i  (wr_data_i),
      .update_i (upd),
      .work_o   (period_w),
      .valid_o  (buf_valid_o[0])
   );

   tmr_counter #(.W(CNT_W)) u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick),
      .restart_i(restart),
      .period_i (period_w),
      .count_o  (count_o),
      .wrap_o   (upd)
   );

   // compare channels
   for (genvar i = 0; i < N_CH; i++) begin : g_cmp
      logic [CNT_W-1:0] cmp_w;
      tmr_shadow #(.W(CNT_W), .WORK_RST('1)) u_cmp (
         .clk_i    (clk_i),
         .rst_ni   (rst_ni),
         .wr_work_i(wr_en_i && wr_addr_i == ADDR_W'(A_CMP0 + 2 * i)),
         .wr_buf_i (wr_en_i && wr_addr_i == ADDR_W'(A_CMP0 + 2 * i + 1)),
         .wdata_i  (wr_data_i),
         .update_i (upd),
         .work_o   (cmp_w),
         .valid_o  (buf_valid_o[i+1])
      );
      assign match_o[i] = tick && !restart && (count_o == cmp_w);
   end

   assign period_o = period_w;
   assign update_o = upd;
endmodule

// File: rtl/buf_timer_checker.sv
module buf_timer_checker #(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned N_CH   = 4,
   parameter int unsigned ADDR_W = 4
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic [3:0]        sel,
   input logic              act_en,
   input logic              wr_en_i,
   input logic [ADDR_W-1:0] wr_addr_i,
   input logic [CNT_W-1:0]  count_o,
   input logic              update_o,
   input logic [N_CH:0]     buf_valid_o,
   input logic [N_CH-1:0]   match_o
);
   logic pbuf_wr;
   assign pbuf_wr = wr_en_i && (wr_addr_i == ADDR_W'(2));

   assert_off_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel == 4'd0) |=> $stable(count_o));

   assert_pre1_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel == 4'd1 && !act_en && !update_o) |=> (count_o == CNT_W'($past(count_o) + 1'b1)));

   assert_wrap_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      update_o |=> (count_o == '0));

   assert_valid_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pbuf_wr |=> buf_valid_o[0]);

   assert_valid_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (update_o && !pbuf_wr) |=> !buf_valid_o[0]);

   assert_match_counts_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (match_o != '0 && !update_o) |=> (count_o == CNT_W'($past(count_o) + 1'b1)));

   assert_act_stop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (act_en && sel < 4'd8) |=> $stable(count_o));
endmodule

bind buf_timer buf_timer_checker #(.CNT_W(CNT_W), .N_CH(N_CH), .ADDR_W(ADDR_W)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .sel        (ctrl_q.sel),
   .act_en     (ctrl_q.act_en),
   .wr_en_i    (wr_en_i),
   .wr_addr_i  (wr_addr_i),
   .count_o    (count_o),
   .update_o   (update_o),
   .buf_valid_o(buf_valid_o),
   .match_o    (match_o)
);

// File: tb/buf_timer_test.sv
module buf_timer_test;
   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic        wr_en_i = 1'b0;
   logic [3:0]  wr_addr_i = '0;
   logic [15:0] wr_data_i = '0;
   logic [3:0]  event_i = '0;
   logic [15:0] count_o;
   logic [15:0] period_o;
   logic [4:0]  buf_valid_o;
   logic [3:0]  match_o;
   logic        update_o;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   logic [3:0]  s_match;
   logic        s_upd;
   logic [15:0] s_cnt;

   always #4 clk_i = ~clk_i;

   buf_timer uut (
      .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
      .wr_data_i(wr_data_i), .event_i(event_i), .count_o(count_o),
      .period_o(period_o), .buf_valid_o(buf_valid_o), .match_o(match_o),
      .update_o(update_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk_i);
      wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
      @(posedge clk_i); #1;
      wr_en_i = 1'b0;
   endtask

   task automatic step(input logic [3:0] m);
      @(negedge clk_i);
      event_i = m;
      #1;
      s_match = match_o; s_upd = update_o; s_cnt = count_o;
      @(posedge clk_i); #1;
      event_i = '0;
   endtask

   task automatic wr_step(input logic [3:0] a, input logic [15:0] d, input logic [3:0] m);
      @(negedge clk_i);
      wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d; event_i = m;
      #1;
      s_match = match_o; s_upd = update_o; s_cnt = count_o;
      @(posedge clk_i); #1;
      wr_en_i = 1'b0; event_i = '0;
   endtask

   // control value: event select 0 counting, action enabled on channel 1
   localparam logic [15:0] CTRL_EVACT = 16'd8 | 16'd16 | (16'd1 << 5);

   initial begin
      repeat (200000) @(posedge clk_i);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [15:0] c0;
      repeat (3) @(posedge clk_i);
      #1 rst_ni = 1'b1;

      // R1 reset state
      @(negedge clk_i);
      chk(count_o == 0, "R1 count", count_o, 0);
      chk(period_o == 16'hFFFF, "R1 period", period_o, 16'hFFFF);
      chk(buf_valid_o == 0, "R1 valid", buf_valid_o, 0);
      chk(match_o == 0 && update_o == 0, "R1 pulses", {match_o, update_o}, 0);
      repeat (20) @(posedge clk_i);
      #1 chk(count_o == 0, "R1 off holds", count_o, 0);

      // R2 prescaler taps
      for (int k = 1; k <= 7; k++) begin
         int sh;
         sh = (k <= 4) ? k - 1 : (k == 5 ? 6 : (k == 6 ? 8 : 10));
         wr(4'd0, 16'(k));
         c0 = count_o;
         repeat (2048) @(posedge clk_i);
         #1 chk(16'(count_o - c0) == 16'(2048 >> sh), "R2 tap delta",
                16'(count_o - c0), 2048 >> sh);
      end

      // R1 off again
      wr(4'd0, 16'd0);
      c0 = count_o;
      repeat (50) @(posedge clk_i);
      #1 chk(count_o == c0, "R1 stopped", count_o, c0);

      // R9 event-action restart
      wr(4'd0, CTRL_EVACT);
      step(4'b0010);
      chk(count_o == 0, "R9 restart", count_o, 0);
      chk(s_upd == 0 && s_match == 0, "R9 no pulse", {s_match, s_upd}, 0);
      step(4'b0001);
      chk(count_o == 1, "R9 counts after", count_o, 1);
      step(4'b0011);
      chk(count_o == 0, "R9 restart priority", count_o, 0);

      // R10 action with a prescaler source
      wr(4'd0, 16'd16 | 16'd1);
      c0 = count_o;
      repeat (30) @(posedge clk_i);
      step(4'b1111);
      chk(count_o == c0, "R10 held", count_o, c0);

      // R3 event channel select, all masks
      for (int ch = 0; ch < 4; ch++) begin
         wr(4'd0, 16'(8 + ch));
         for (int m = 0; m < 16; m++) begin
            c0 = count_o;
            step(4'(m));
            chk(count_o == 16'(c0 + ((m >> ch) & 1)), "R3 event count",
                count_o, c0 + ((m >> ch) & 1));
         end
      end

      // R8 direct period, R4 wrap
      wr(4'd0, CTRL_EVACT);
      wr(4'd1, 16'd5);
      chk(period_o == 5, "R8 direct period", period_o, 5);
      step(4'b0010);
      for (int i = 0; i < 6; i++) begin
         step(4'b0001);
         chk(s_upd == (i == 5), "R4 update pulse", s_upd, i == 5);
      end
      chk(count_o == 0, "R4 wrapped", count_o, 0);

      // R5 buffered period
      wr(4'd2, 16'd3);
      chk(buf_valid_o[0] == 1, "R5 valid set", buf_valid_o[0], 1);
      for (int i = 0; i < 5; i++) step(4'b0001);
      chk(period_o == 5 && count_o == 5, "R5 held until update", period_o, 5);
      step(4'b0001);
      chk(period_o == 3, "R5 loaded", period_o, 3);
      chk(buf_valid_o[0] == 0, "R5 valid clear", buf_valid_o[0], 0);

      // R6 buffer write on the update cycle
      wr(4'd2, 16'd6);
      for (int i = 0; i < 3; i++) step(4'b0001);
      wr_step(4'd2, 16'd2, 4'b0001);
      chk(s_upd == 1, "R6 update cycle", s_upd, 1);
      chk(period_o == 6, "R6 old buffer loaded", period_o, 6);
      chk(buf_valid_o[0] == 1, "R6 valid kept", buf_valid_o[0], 1);
      for (int i = 0; i < 7; i++) step(4'b0001);
      chk(period_o == 2 && buf_valid_o[0] == 0, "R6 new value next update", period_o, 2);

      // R7 compare sweep
      wr(4'd1, 16'd7);
      for (int c = 0; c < 8; c++) begin
         int ch;
         ch = c % 4;
         wr(4'(3 + 2 * ch), 16'(c));
         step(4'b0010);
         for (int i = 0; i < 8; i++) begin
            step(4'b0001);
            chk(s_match[ch] == (s_cnt == 16'(c)), "R7 match", s_match[ch], s_cnt == 16'(c));
         end
      end
      // R7 no match on an idle cycle
      wr(4'd3, 16'd0);
      step(4'b0010);
      @(negedge clk_i); #1;
      chk(count_o == 0 && match_o[0] == 0, "R7 idle no match", match_o[0], 0);

      // R5 buffered compare on channel 0
      wr(4'd4, 16'd3);
      chk(buf_valid_o[1] == 1, "R5 cmp valid set", buf_valid_o[1], 1);
      for (int i = 0; i < 8; i++) begin
         step(4'b0001);
         chk(s_match[0] == (s_cnt == 0), "R5 cmp old value", s_match[0], s_cnt == 0);
      end
      chk(buf_valid_o[1] == 0, "R5 cmp valid clear", buf_valid_o[1], 0);
      for (int i = 0; i < 8; i++) begin
         step(4'b0001);
         chk(s_match[0] == (s_cnt == 3), "R5 cmp new value", s_match[0], s_cnt == 3);
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule